// File: doc/BRIEF.md
# Register-Addressed I2C Transaction Sequencer

This block runs whole register-addressed transactions against a slave on an I2C bus. It does not drive the bus wires itself. It works above a bit-level engine and hands that engine one command at a time: START, STOP, write one byte, or read one byte. Each command is held until the engine reports completion. For a write command the engine returns the slave's acknowledge bit, and for a read command it returns the byte read. Three kinds of transaction are supported: a probe (address byte only), a read of N bytes, and a write of N bytes.

A request carries the kind of transaction, a 7-bit chip address, a register address of zero up to `ADDR_BYTES_MAX` bytes, a byte count, and a flag. For reads, the flag chooses the gap between the address phase and the data phase: either a lone repeated START, or a STOP followed by a START. Write data enters on a valid/ready port and read data leaves on another one. Optionally, the register-address bits above the sent length can be ORed into the chip address under a mask. This serves memories that hide high address bits in the chip-address field. When the final STOP completes, the block pulses `done` and shows a status code. It also shows how many write-data bytes were not acknowledged.

Top module: `i2c_txn_seq`

## Requirements
- R1: A probe (kind 0) issues START, then a write of {chip,0}, then STOP. Status is 0 when the slave acknowledged and 1 when it did not.
- R2: Register-address bytes go out as engine writes, most significant byte first. Exactly `alen` of them are sent after the {chip,0} byte.
- R3: With folding enabled, the chip address used in every address byte equals chip OR ((register address >> 8*alen) AND FOLD_MASK).
- R4: In a read (kind 1) with alen > 0, the address phase is followed by START, then {chip,1}. When the gap flag is 0, a STOP comes before that START.
- R5: In a read with alen = 0, START is followed directly by {chip,1}, and no {chip,0} byte or address byte is sent.
- R6: Each data byte is read with the ack-out bit 0, except the last byte, which uses 1. STOP follows the last byte. Bytes leave on the read port in order, and `rd_data` holds while `rd_valid` is high and `rd_ready` is low.
- R7: A write (kind 2) sends START, {chip,0}, the address bytes, and then N data bytes taken in order from the write port, followed by STOP.
- R8: A NACK on a write-data byte increments `fail_count`, which saturates and is cleared when a request is accepted. The transfer goes on and the status stays 0.
- R9: A NACK on the {chip,0} byte, or on the {chip,1} byte of a read, ends the transaction with STOP and status 1. No further byte is moved.
- R10: A NACK on any register-address byte ends the transaction with STOP and status 2.
- R11: A read with count 0 performs the addressing, sends {chip,1}, and then issues only STOP.
- R12: `done` is high for exactly one cycle, the cycle after the engine completes the final STOP. `req_ready` is high only while idle, and an engine command stays stable until `eng_done`. Engine op codes are: 0 START, 1 STOP, 2 write byte, 3 read byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request taken |
| req_kind | input | 2 | 0 probe, 1 read, 2 write |
| req_chip | input | 7 | Slave chip address |
| req_addr | input | 8*ADDR_BYTES_MAX | Register address |
| req_alen | input | ALEN_W | Register address length in bytes |
| req_count | input | CNT_W | Data byte count |
| req_rep_start | input | 1 | Read gap: 1 repeated START, 0 STOP then START |
| wr_valid | input | 1 | Write byte present |
| wr_ready | output | 1 | Write byte taken |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte present |
| rd_ready | input | 1 | Read byte taken |
| rd_data | output | 8 | Read byte |
| done | output | 1 | One-cycle end-of-transaction pulse |
| status | output | 2 | 0 ok, 1 chip NACK, 2 address NACK |
| fail_count | output | FAIL_W | Unacknowledged write-data bytes |
| eng_req | output | 1 | Engine command valid |
| eng_op | output | 2 | Engine command code |
| eng_tx | output | 8 | Byte for write command |
| eng_nack_out | output | 1 | Ack-out level for read command (1 = NACK) |
| eng_done | input | 1 | Engine finished current command |
| eng_rx | input | 8 | Byte returned by read command |
| eng_rx_nack | input | 1 | Slave NACK seen by write command |

## Verification
The bench builds the block with four address bytes, folding enabled and a fold mask of 3. This makes the widest address (four bytes, where the fold shift drops everything) and a masked fold of a one-byte address reachable in the same build. An engine model in the bench answers every command after a fixed latency and returns NACKs at chosen byte positions. These positions let each abort point be reached: chip byte, read-chip byte, and each address byte. A throttled read-ready exercises the hold behaviour of the read port, and a run in which every write-data byte is NACKed drives the failure counter well past one.

// File: rtl/i2cs_pkg.sv
// Shared codes for the transaction sequencer.
// Assumes: engine op codes and status codes are fixed by the requirements.
package i2cs_pkg;
    localparam logic [1:0] OP_START = 2'd0;
    localparam logic [1:0] OP_STOP  = 2'd1;
    localparam logic [1:0] OP_WRITE = 2'd2;
    localparam logic [1:0] OP_READ  = 2'd3;

    localparam logic [1:0] KIND_PROBE = 2'd0;
    localparam logic [1:0] KIND_READ  = 2'd1;
    localparam logic [1:0] KIND_WRITE = 2'd2;

    localparam logic [1:0] STAT_OK        = 2'd0;
    localparam logic [1:0] STAT_CHIP_NACK = 2'd1;
    localparam logic [1:0] STAT_ADDR_NACK = 2'd2;

    typedef enum logic [3:0] {
        S_IDLE, S_START, S_CHIPW, S_ADDR, S_GSTOP, S_RSTART,
        S_CHIPR, S_RBYTE, S_RPUSH, S_WFETCH, S_WBYTE, S_STOP
    } seq_state_t;
endpackage

// File: rtl/i2cs_chip_fold.sv
// Chip-address folding: ORs the register-address bits above the sent
// length into the chip address, under a mask.
// Assumes: alen never exceeds the address width in bytes.
module i2cs_chip_fold #(
    parameter int         ADDR_BYTES = 4,
    parameter int         ALEN_W     = 3,
    parameter bit         FOLD_EN    = 1'b0,
    parameter logic [6:0] FOLD_MASK  = 7'h07,
    localparam int        ADDR_W     = 8 * ADDR_BYTES
) (
    input  logic [6:0]        chip_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ALEN_W-1:0] alen_i,
    output logic [6:0]        chip_o
);
    logic [ALEN_W+2:0] shamt;
    logic [6:0]        upper;

    // Bits left over above the address bytes actually sent.
    always_comb begin
        shamt = {alen_i, 3'b000};
        upper = 7'(addr_i >> shamt);
    end

    generate
        if (FOLD_EN) begin : g_fold
            assign chip_o = chip_i | (upper & FOLD_MASK);
        end else begin : g_plain
            assign chip_o = chip_i | (upper & 7'h00);
        end
    endgenerate
endmodule

// File: rtl/i2cs_byte_pick.sv
// Register-address byte selector: returns byte number sel_i of the address.
// Assumes: sel_i < N; any other value returns zero.
module i2cs_byte_pick #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [8*N-1:0]  addr_i,
    input  logic [IDX_W-1:0] sel_i,
    output logic [7:0]       byte_o
);
    logic [7:0] lane [N];

    for (genvar g = 0; g < N; g++) begin : g_lane
        assign lane[g] = addr_i[8*g +: 8];
    end

    // Plain mux over the byte lanes.
    always_comb begin
        byte_o = 8'h00;
        for (int k = 0; k < N; k++) begin
            if (sel_i == IDX_W'(k)) byte_o = lane[k];
        end
    end
endmodule

// File: rtl/i2cs_fail_ctr.sv
// Saturating counter of write-data bytes the slave did not acknowledge.
// Assumes: clr and inc are never high in the same cycle.
module i2cs_fail_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count_o
);
    logic [W-1:0] cnt_q;

    // Clear on a new request, count up to all ones and stay there.
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt_q <= '0;
        else if (clr)                cnt_q <= '0;
        else if (inc && !(&cnt_q))   cnt_q <= cnt_q + 1'b1;
    end

    assign count_o = cnt_q;

    AST_FAIL_MONO: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> cnt_q >= $past(cnt_q)); // R8
    AST_FAIL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !inc) |=> $stable(cnt_q)); // R8
endmodule

// File: rtl/i2c_txn_seq.sv
// Transaction sequencer: turns one probe/read/write request into a list
// of engine commands (START, STOP, byte write, byte read), streams data
// over valid/ready ports and reports a status code at the end.
// Assumes: the engine holds eng_done for one cycle per accepted command,
// and req_alen <= ADDR_BYTES_MAX.
module i2c_txn_seq
    import i2cs_pkg::*;
#(
    parameter int         ADDR_BYTES_MAX = 4,
    parameter int         CNT_W          = 8,
    parameter int         FAIL_W         = 8,
    parameter bit         FOLD_EN        = 1'b0,
    parameter logic [6:0] FOLD_MASK      = 7'h07,
    localparam int        ADDR_W         = 8 * ADDR_BYTES_MAX,
    localparam int        ALEN_W         = $clog2(ADDR_BYTES_MAX + 1),
    localparam int        IDX_W          = (ADDR_BYTES_MAX > 1) ? $clog2(ADDR_BYTES_MAX) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic [6:0]        req_chip,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ALEN_W-1:0] req_alen,
    input  logic [CNT_W-1:0]  req_count,
    input  logic              req_rep_start,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [7:0]        wr_data,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [7:0]        rd_data,
    output logic              done,
    output logic [1:0]        status,
    output logic [FAIL_W-1:0] fail_count,
    output logic              eng_req,
    output logic [1:0]        eng_op,
    output logic [7:0]        eng_tx,
    output logic              eng_nack_out,
    input  logic              eng_done,
    input  logic [7:0]        eng_rx,
    input  logic              eng_rx_nack
);
    seq_state_t        state_q;
    logic [1:0]        kind_q;
    logic [6:0]        chip_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ALEN_W-1:0] alen_q;
    logic [ALEN_W-1:0] left_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              rep_q;
    logic [7:0]        wbyte_q;
    logic [7:0]        rbyte_q;
    logic [1:0]        status_q;
    logic              done_q;

    logic [6:0]        chip_folded;
    logic [IDX_W-1:0]  addr_sel;
    logic [7:0]        addr_byte;
    logic              accept;
    logic              fail_inc;
    logic              last_cnt;

    i2cs_chip_fold #(
        .ADDR_BYTES (ADDR_BYTES_MAX),
        .ALEN_W     (ALEN_W),
        .FOLD_EN    (FOLD_EN),
        .FOLD_MASK  (FOLD_MASK)
    ) i_fold (
        .chip_i (req_chip),
        .addr_i (req_addr),
        .alen_i (req_alen),
        .chip_o (chip_folded)
    );

    assign addr_sel = IDX_W'(left_q - ALEN_W'(1));

    i2cs_byte_pick #(
        .N     (ADDR_BYTES_MAX),
        .IDX_W (IDX_W)
    ) i_pick (
        .addr_i (addr_q),
        .sel_i  (addr_sel),
        .byte_o (addr_byte)
    );

    assign accept   = (state_q == S_IDLE) && req_valid;
    assign fail_inc = (state_q == S_WBYTE) && eng_done && eng_rx_nack;
    assign last_cnt = (cnt_q == CNT_W'(1));

    i2cs_fail_ctr #(
        .W (FAIL_W)
    ) i_fail (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (accept),
        .inc     (fail_inc),
        .count_o (fail_count)
    );

    // Main sequence: one state per engine command or port handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            kind_q   <= KIND_PROBE;
            chip_q   <= '0;
            addr_q   <= '0;
            alen_q   <= '0;
            left_q   <= '0;
            cnt_q    <= '0;
            rep_q    <= 1'b0;
            wbyte_q  <= '0;
            rbyte_q  <= '0;
            status_q <= STAT_OK;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                S_IDLE: if (req_valid) begin
                    kind_q   <= req_kind;
                    chip_q   <= chip_folded;
                    addr_q   <= req_addr;
                    alen_q   <= req_alen;
                    cnt_q    <= req_count;
                    rep_q    <= req_rep_start;
                    status_q <= STAT_OK;
                    state_q  <= S_START;
                end
                S_START: if (eng_done) begin
                    if (kind_q == KIND_READ && alen_q == '0) state_q <= S_CHIPR;
                    else                                     state_q <= S_CHIPW;
                end
                S_CHIPW: if (eng_done) begin
                    left_q <= alen_q;
                    if (eng_rx_nack) begin
                        status_q <= STAT_CHIP_NACK;
                        state_q  <= S_STOP;
                    end else if (kind_q == KIND_PROBE) begin
                        state_q <= S_STOP;
                    end else if (alen_q != '0) begin
                        state_q <= S_ADDR;
                    end else begin
                        state_q <= (cnt_q == '0) ? S_STOP : S_WFETCH;
                    end
                end
                S_ADDR: if (eng_done) begin
                    if (eng_rx_nack) begin
                        status_q <= STAT_ADDR_NACK;
                        state_q  <= S_STOP;
                    end else if (left_q != ALEN_W'(1)) begin
                        left_q <= left_q - ALEN_W'(1);
                    end else if (kind_q == KIND_READ) begin
                        state_q <= rep_q ? S_RSTART : S_GSTOP;
                    end else begin
                        state_q <= (cnt_q == '0) ? S_STOP : S_WFETCH;
                    end
                end
                S_GSTOP:  if (eng_done) state_q <= S_RSTART;
                S_RSTART: if (eng_done) state_q <= S_CHIPR;
                S_CHIPR: if (eng_done) begin
                    if (eng_rx_nack) begin
                        status_q <= STAT_CHIP_NACK;
                        state_q  <= S_STOP;
                    end else begin
                        state_q <= (cnt_q == '0) ? S_STOP : S_RBYTE;
                    end
                end
                S_RBYTE: if (eng_done) begin
                    rbyte_q <= eng_rx;
                    state_q <= S_RPUSH;
                end
                S_RPUSH: if (rd_ready) begin
                    cnt_q   <= cnt_q - CNT_W'(1);
                    state_q <= last_cnt ? S_STOP : S_RBYTE;
                end
                S_WFETCH: if (wr_valid) begin
                    wbyte_q <= wr_data;
                    state_q <= S_WBYTE;
                end
                S_WBYTE: if (eng_done) begin
                    cnt_q   <= cnt_q - CNT_W'(1);
                    state_q <= last_cnt ? S_STOP : S_WFETCH;
                end
                S_STOP: if (eng_done) begin
                    done_q  <= 1'b1;
                    state_q <= S_IDLE;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // Engine command decode from the current state.
    always_comb begin
        eng_req      = 1'b1;
        eng_op       = OP_WRITE;
        eng_tx       = 8'h00;
        eng_nack_out = 1'b0;
        case (state_q)
            S_START, S_RSTART: eng_op = OP_START;
            S_GSTOP, S_STOP:   eng_op = OP_STOP;
            S_CHIPW:           eng_tx = {chip_q, 1'b0};
            S_CHIPR:           eng_tx = {chip_q, 1'b1};
            S_ADDR:            eng_tx = addr_byte;
            S_WBYTE:           eng_tx = wbyte_q;
            S_RBYTE: begin
                eng_op       = OP_READ;
                eng_nack_out = last_cnt;
            end
            default:           eng_req = 1'b0;
        endcase
    end

    assign req_ready = (state_q == S_IDLE);
    assign wr_ready  = (state_q == S_WFETCH);
    assign rd_valid  = (state_q == S_RPUSH);
    assign rd_data   = rbyte_q;
    assign done      = done_q;
    assign status    = status_q;

    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && !eng_done) |=> (eng_req && $stable(eng_op) && $stable(eng_tx))); // R12
    AST_DONE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(eng_done && eng_req && eng_op == OP_STOP)); // R12
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!eng_req && !rd_valid && !wr_ready)); // R12
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data))); // R6
    AST_ABORT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && eng_rx_nack && (state_q == S_CHIPW || state_q == S_ADDR || state_q == S_CHIPR))
        |=> (eng_req && eng_op == OP_STOP)); // R9
    AST_DATA_NACK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && state_q == S_WBYTE) |=> $stable(status)); // R8
endmodule

// File: tb/test_i2c_txn_seq.sv
`timescale 1ns/1ps
module test_i2c_txn_seq;
    localparam int AB      = 4;
    localparam int CNT_W   = 8;
    localparam int ALEN_W  = 3;
    localparam int ENG_LAT = 2;

    localparam int OPS = 0, OPP = 1, OPW = 2, OPR = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [1:0]        req_kind = '0;
    logic [6:0]        req_chip = '0;
    logic [8*AB-1:0]   req_addr = '0;
    logic [ALEN_W-1:0] req_alen = '0;
    logic [CNT_W-1:0]  req_count = '0;
    logic              req_rep_start = 1'b0;
    logic              wr_valid = 1'b1;
    logic              wr_ready;
    logic [7:0]        wr_data = 8'h30;
    logic              rd_valid;
    logic              rd_ready = 1'b1;
    logic [7:0]        rd_data;
    logic              done;
    logic [1:0]        status;
    logic [7:0]        fail_count;
    logic              eng_req;
    logic [1:0]        eng_op;
    logic [7:0]        eng_tx;
    logic              eng_nack_out;
    logic              eng_done = 1'b0;
    logic [7:0]        eng_rx = '0;
    logic              eng_rx_nack = 1'b0;

    int total = 0;
    int bad   = 0;

    i2c_txn_seq #(
        .ADDR_BYTES_MAX (AB),
        .CNT_W          (CNT_W),
        .FAIL_W         (8),
        .FOLD_EN        (1'b1),
        .FOLD_MASK      (7'h03)
    ) i_i2c_txn_seq (
        .clk, .rst_n, .req_valid, .req_ready, .req_kind, .req_chip,
        .req_addr, .req_alen, .req_count, .req_rep_start,
        .wr_valid, .wr_ready, .wr_data, .rd_valid, .rd_ready, .rd_data,
        .done, .status, .fail_count, .eng_req, .eng_op, .eng_tx,
        .eng_nack_out, .eng_done, .eng_rx, .eng_rx_nack
    );

    always #10 clk = ~clk;

    // Command log from the engine model and the expected list.
    int        log_n = 0;
    logic [10:0] log_e [64];
    int        exp_n = 0;
    logic [10:0] exp_e [64];
    logic [63:0] nack_mask = '0;
    int        wcount = 0;
    int        rcount = 0;
    int        wr_ix = 0;
    bit        wr_pend = 0;
    int        rd_n = 0;
    logic [7:0] rd_got [64];
    bit        throttle = 0;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // Engine model: answers each command after a fixed latency.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && eng_req) begin
                logic [1:0] op;
                logic       nk;
                logic [7:0] rx;
                op = eng_op;
                nk = 1'b0;
                rx = 8'h00;
                if (log_n < 64) begin
                    log_e[log_n] = {op, (op == 2'(OPW)) ? eng_tx : 8'h00,
                                    (op == 2'(OPR)) ? eng_nack_out : 1'b0};
                    log_n++;
                end
                if (op == 2'(OPW)) begin nk = nack_mask[wcount]; wcount++; end
                if (op == 2'(OPR)) begin rx = 8'hA0 + 8'(rcount); rcount++; end
                repeat (ENG_LAT) @(negedge clk);
                eng_rx = rx;
                eng_rx_nack = nk;
                eng_done = 1'b1;
                @(negedge clk);
                eng_done = 1'b0;
                eng_rx_nack = 1'b0;
            end
        end
    end

    // Write source and read sink, both driven away from the clock edge.
    initial begin
        forever begin
            @(negedge clk);
            if (wr_pend) begin
                wr_ix++;
                wr_data = 8'h30 + 8'(wr_ix);
                wr_pend = 0;
            end
            if (wr_valid && wr_ready) wr_pend = 1;
            rd_ready = throttle ? ~rd_ready : 1'b1;
            if (rd_valid && rd_ready && rd_n < 64) begin
                rd_got[rd_n] = rd_data;
                rd_n++;
            end
        end
    end

    task automatic e_clear(); exp_n = 0; endtask
    task automatic e_add(input int op, input int b, input bit f);
        exp_e[exp_n] = {2'(op), 8'(b), f};
        exp_n++;
    endtask

    task automatic cmp_seq(input string rq);
        chk(log_n == exp_n, rq, log_n, exp_n);
        for (int i = 0; i < exp_n && i < log_n; i++)
            chk(log_e[i] == exp_e[i], rq, int'(log_e[i]), int'(exp_e[i]));
    endtask

    task automatic run_txn(input int kind, input int chip, input logic [31:0] addr,
                           input int alen, input int cnt, input bit rep,
                           input logic [63:0] nmask, input bit thr);
        log_n = 0; wcount = 0; rcount = 0; rd_n = 0;
        wr_ix = 0; wr_data = 8'h30; nack_mask = nmask; throttle = thr;
        @(negedge clk);
        req_kind = 2'(kind); req_chip = 7'(chip); req_addr = addr;
        req_alen = ALEN_W'(alen); req_count = CNT_W'(cnt); req_rep_start = rep;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
    endtask

    task automatic after_done(input int st, input int fc, input string rq);
        chk(status == 2'(st), rq, status, st);
        chk(fail_count == 8'(fc), rq, fail_count, fc);
        @(negedge clk);
        chk(!done && req_ready, "R12", {done, req_ready}, 1);
    endtask

    task automatic t_reset();
        chk(req_ready && !done && !eng_req && status == 0 && fail_count == 0,
            "R12", {req_ready, done, eng_req}, 4);
    endtask

    task automatic t_probe();
        run_txn(0, 7'h50, 0, 0, 0, 0, 64'h0, 0);
        e_clear(); e_add(OPS, 0, 0); e_add(OPW, 8'hA0, 0); e_add(OPP, 0, 0);
        cmp_seq("R1");
        after_done(0, 0, "R1");
        run_txn(0, 7'h50, 0, 0, 0, 0, 64'h1, 0);
        cmp_seq("R1");
        after_done(1, 0, "R1");
    endtask

    task automatic t_read_rep();
        run_txn(1, 7'h50, 32'h0102, 2, 3, 1, 64'h0, 1);
        e_clear(); e_add(OPS, 0, 0); e_add(OPW, 8'hA0, 0); e_add(OPW, 8'h01, 0);
        e_add(OPW, 8'h02, 0); e_add(OPS, 0, 0); e_add(OPW, 8'hA1, 0);
        e_add(OPR, 0, 0); e_add(OPR, 0, 0); e_add(OPR, 0, 1); e_add(OPP, 0, 0);
        cmp_seq("R4");
        chk(rd_n == 3, "R6", rd_n, 3);
        for (int i = 0; i < 3; i++) chk(rd_got[i] == 8'hA0 + 8'(i), "R6", rd_got[i], 8'hA0 + i);
        after_done(0, 0, "R6");
    endtask

    task automatic t_read_gap_stop();
        run_txn(1, 7'h50, 32'h07, 1, 1, 0, 64'h0, 0);
        e_clear(); e_add(OPS, 0, 0); e_add(OPW, 8'hA0, 0); e_add(OPW, 8'h07, 0);
        e_add(OPP, 0, 0); e_add(OPS, 0, 0); e_add(OPW, 8'hA1, 0);
        e_add(OPR, 0, 1); e_add(OPP, 0, 0);
        cmp_seq("R4");
        chk(rd_n == 1 && rd_got[0] == 8'hA0, "R6", rd_got[0], 8'hA0);
        after_done(0, 0, "R4");
    endtask

    task automatic t_read_noaddr();
        run_txn(1, 7'h50, 0, 0, 2, 0, 64'h0, 0);
        e_clear(); e_add(OPS, 0, 0); e_add(OPW, 8'hA1, 0);
        e_add(OPR, 0, 0); e_add(OPR, 0, 1); e_add(OPP, 0, 0);
        cmp_seq("R5");
        after_done(0, 0, "R5");
    endtask

    task automatic t_fold();
        run_txn(1, 7'h50, 32'h0E34, 1, 1, 1, 64'h0, 0);
        e_clear(); e_add(OPS, 0, 0); e_add(OPW, 8'hA4, 0); e_add(OPW, 8'h34, 0);
        e_add(OPS, 0, 0); e_add(OPW, 8'hA5, 0); e_add(OPR, 0, 1); e_add(OPP, 0, 0);
        cmp_seq("R3");
        after_done(0, 0, "R3");
    endtask

    task automatic t_read_zero();
        run_txn(1, 7'h50, 32'h07, 1, 0, 1, 64'h0, 0);
        e_clear(); e_add(OPS, 0, 0); e_add(OPW, 8'hA0, 0); e_add(OPW, 8'h07, 0);
        e_add(OPS, 0, 0); e_add(OPW, 8'hA1, 0); e_add(OPP, 0, 0);
        cmp_seq("R11");
        chk(rd_n == 0, "R11", rd_n, 0);
        after_done(0, 0, "R11");
    endtask

    task automatic t_write();
        run_txn(2, 7'h50, 32'h1234, 2, 3, 0, 64'h10, 0);
        e_clear(); e_add(OPS, 0, 0); e_add(OPW, 8'hA0, 0); e_add(OPW, 8'h12, 0);
        e_add(OPW, 8'h34, 0); e_add(OPW, 8'h30, 0); e_add(OPW, 8'h31, 0);
        e_add(OPW, 8'h32, 0); e_add(OPP, 0, 0);
        cmp_seq("R7");
        chk(wr_ix == 3, "R7", wr_ix, 3);
        after_done(0, 1, "R8");
        run_txn(2, 7'h50, 0, 0, 20, 0, 64'hFFFF_FFFF_FFFF_FFFE, 0);
        chk(log_n == 23, "R8", log_n, 23);
        after_done(0, 20, "R8");
    endtask

    task automatic t_wide_addr();
        run_txn(2, 7'h50, 32'h89ABCDEF, 4, 0, 0, 64'h0, 0);
        e_clear(); e_add(OPS, 0, 0); e_add(OPW, 8'hA0, 0); e_add(OPW, 8'h89, 0);
        e_add(OPW, 8'hAB, 0); e_add(OPW, 8'hCD, 0); e_add(OPW, 8'hEF, 0); e_add(OPP, 0, 0);
        cmp_seq("R2");
        after_done(0, 0, "R2");
    endtask

    task automatic t_aborts();
        run_txn(2, 7'h50, 32'h12, 1, 2, 0, 64'h1, 0);
        e_clear(); e_add(OPS, 0, 0); e_add(OPW, 8'hA0, 0); e_add(OPP, 0, 0);
        cmp_seq("R9");
        chk(wr_ix == 0, "R9", wr_ix, 0);
        after_done(1, 0, "R9");
        run_txn(1, 7'h50, 0, 0, 2, 0, 64'h1, 0);
        e_clear(); e_add(OPS, 0, 0); e_add(OPW, 8'hA1, 0); e_add(OPP, 0, 0);
        cmp_seq("R9");
        after_done(1, 0, "R9");
        run_txn(1, 7'h50, 32'h5566, 2, 2, 1, 64'h4, 0);
        e_clear(); e_add(OPS, 0, 0); e_add(OPW, 8'hA0, 0); e_add(OPW, 8'h55, 0);
        e_add(OPW, 8'h66, 0); e_add(OPP, 0, 0);
        cmp_seq("R10");
        after_done(2, 0, "R10");
        run_txn(2, 7'h50, 32'h77, 1, 2, 0, 64'h2, 0);
        e_clear(); e_add(OPS, 0, 0); e_add(OPW, 8'hA0, 0); e_add(OPW, 8'h77, 0);
        e_add(OPP, 0, 0);
        cmp_seq("R10");
        after_done(2, 0, "R10");
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_probe();
        t_read_rep();
        t_read_gap_stop();
        t_read_noaddr();
        t_fold();
        t_read_zero();
        t_write();
        t_wide_addr();
        t_aborts();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule